// File: doc/BRIEF.md
# Clock Post-Divider with Glitch-Free Output Enable

This block turns a fast tick clock into a divided output clock with an even duty cycle. A 2-bit ratio code, supplied by a neighbouring configuration block, selects one of four power-of-two division settings, including a pass-through setting. The output is a true/complement pair of logic bits, both produced from a single output register. The analog driver that would normally take this pair is not part of the block.

The block is clocked at twice the rate of the undivided source, so every half period of the output spans a whole number of ticks. At the pass-through setting the output toggles on every tick. All decisions are made at one point of the waveform: the tick where a high phase ends and a low phase begins. A new ratio code and the output enable are both sampled at that point. As a result, a stop always follows a complete high pulse, a restart always begins with a complete low phase, and a ratio change never emits a shortened pulse. A synchronous reset clears the divider and parks the pair at low/high.

Top module: `clk_post_div`

## Requirements
- R1: Ratio code 2'b00 selects divide-by-1, 2'b01 divide-by-2, 2'b10 divide-by-4 and 2'b11 divide-by-8. At divide-by-N, each output high phase lasts N ticks of `clk`, so the output period is 2N ticks.
- R2: The duty cycle is 50% at every ratio. While enabled, each low phase lasts exactly as many ticks as the high phase next to it.
- R3: `out_n` is the logical complement of `out_p` on every tick, including during reset and while disabled.
- R4: While the output is disabled, `out_p` is held low and `out_n` is held high.
- R5: A change on `oe` takes effect only where a high phase ends. Every high pulse on `out_p` is full length, including the last pulse before a stop and the first pulse after a restart. A low pulse on `oe` that starts and ends inside one high phase has no effect.
- R6: A new ratio code takes effect at the next high-to-low transition. A high phase in progress completes at the old length, and the low and high phases that follow use the new length. A code that changes during a low phase leaves that low phase and the following high phase at the old length.
- R7: A synchronous reset (`rst` high at a rising edge of `clk`) drives `out_p` low on that edge and clears the divider. After release, `out_p` stays low for at least 2N ticks, where N is the ratio present at release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, twice the undivided source rate |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | RATIO_W (2) | Division code: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 |
| oe | input | 1 | Output enable, active high, applied at the end of a high phase |
| out_p | output | 1 | Divided clock, true side |
| out_n | output | 1 | Divided clock, complement side |

## Verification
All four codes are swept in two orders, and the length of a high phase and of the low phase after it is measured once the output has settled. This separates a wrong ratio decode from a skewed duty cycle. Ratio codes are also changed partway through a high phase and partway through a low phase, which shows whether a new code is applied at the falling boundary or mid-phase. The enable is dropped partway through a high pulse, briefly pulsed low inside a high phase, and raised at an arbitrary point; every high pulse is then held to full length, so any enable path that cuts the output directly produces a runt. A reset in the middle of a pulse, followed by a check of the low stretch after release, covers the reset behaviour.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // Number of ticks in one half period for a given ratio code.
  function automatic int half_ticks(input int code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/pdiv_ratio_hold.sv
module pdiv_ratio_hold #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic               wrap,
  output logic [RATIO_W-1:0] active_q
);

  // The live ratio is swapped only at the high-to-low boundary.
  always_ff @(posedge clk) begin
    if (rst)       active_q <= ratio_sel;
    else if (wrap) active_q <= ratio_sel;
  end

endmodule

// File: rtl/pdiv_phase_cnt.sv
module pdiv_phase_cnt
  import pdiv_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] active,
  output logic               phase_nxt,
  output logic               wrap
);

  localparam int NUM_RATIOS = 1 << RATIO_W;

  logic [CNT_W-1:0]      cnt_q;
  logic                  phase_q;
  logic [NUM_RATIOS-1:0] term_vec;
  logic                  term;

  // One terminal-count comparator per ratio code.
  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_term
    assign term_vec[i] = (cnt_q == CNT_W'(half_ticks(i) - 1));
  end

  assign term      = term_vec[active];
  assign wrap      = phase_q & term;
  assign phase_nxt = phase_q ^ term;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= term ? '0 : cnt_q + CNT_W'(1);
      phase_q <= phase_nxt;
    end
  end

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < half_ticks(int'(active)));

endmodule

// File: rtl/pdiv_out_gate.sv
module pdiv_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic oe,
  input  logic wrap,
  input  logic phase_nxt,
  output logic gate_q,
  output logic out_p,
  output logic out_n
);

  logic gate_nxt;
  logic out_q;

  // The enable is sampled only where a high phase ends.
  assign gate_nxt = wrap ? oe : gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_nxt;
      out_q  <= phase_nxt & gate_nxt;
    end
  end

  // Both sides of the pair come from the same register.
  assign out_p = out_q;
  assign out_n = ~out_q;

  a_r5_gate_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate_q) |-> !out_q);

endmodule

// File: rtl/clk_post_div.sv
module clk_post_div
  import pdiv_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic               oe,
  output logic               out_p,
  output logic               out_n
);

  localparam int NUM_RATIOS = 1 << RATIO_W;
  localparam int CNT_W      = (NUM_RATIOS > 2) ? NUM_RATIOS - 1 : 1;

  logic [RATIO_W-1:0] active;
  logic               wrap;
  logic               phase_nxt;
  logic               gate_q;

  pdiv_ratio_hold #(.RATIO_W(RATIO_W)) ratio_i (
    .clk      (clk),
    .rst      (rst),
    .ratio_sel(ratio_sel),
    .wrap     (wrap),
    .active_q (active)
  );

  pdiv_phase_cnt #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .phase_nxt(phase_nxt),
    .wrap     (wrap)
  );

  pdiv_out_gate gate_i (
    .clk      (clk),
    .rst      (rst),
    .oe       (oe),
    .wrap     (wrap),
    .phase_nxt(phase_nxt),
    .gate_q   (gate_q),
    .out_p    (out_p),
    .out_n    (out_n)
  );

  // Assertion support: length of the current high run.
  int hi_len;
  always_ff @(posedge clk) begin
    if (rst)        hi_len <= 0;
    else if (out_p) hi_len <= hi_len + 1;
    else            hi_len <= 0;
  end

  a_r2_full_high: assert property (@(posedge clk) disable iff (rst)
    $fell(out_p) |-> hi_len == half_ticks(int'($past(active))));

  a_r6_swap_at_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(active) |-> !out_p);

  a_r4_parked: assert property (@(posedge clk) disable iff (rst)
    (!gate_q && !$past(gate_q)) |-> !out_p);

endmodule

// File: tb/clk_post_div_tb_top.sv
module clk_post_div_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] ratio_sel;
  logic       oe;
  logic       out_p, out_n;

  always #10 clk = ~clk;

  clk_post_div #(.RATIO_W(2)) dut_i (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .oe(oe),
    .out_p(out_p), .out_n(out_n)
  );

  int tests = 0;
  int fails = 0;
  int pair_bad = 0;
  int strict_hp = 0;
  int q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures runs on out_p and scores queued expectations.
  logic m_prev;
  int   m_run;
  int   hi_seen;
  bit   armed;
  int   m_exp;
  always @(negedge clk) begin
    if (out_n !== ~out_p) pair_bad++;
    if (rst) begin
      m_prev = 1'b0; m_run = 0; hi_seen = -1; armed = 0;
    end else begin
      if (out_p === m_prev) m_run++;
      else begin
        if (m_prev) begin
          if (strict_hp > 0) chk(m_run == strict_hp, "R5 high pulse full length", m_run, strict_hp);
          if (armed) hi_seen = m_run;
        end else begin
          if (armed && hi_seen >= 0 && q.size() > 0) begin
            m_exp = q[0];
            chk(hi_seen == m_exp, "R1 high phase ticks", hi_seen, m_exp);
            chk(m_run == m_exp, "R2 low phase ticks", m_run, m_exp);
            void'(q.pop_front());
            armed = 0; hi_seen = -1;
          end else if (q.size() > 0) armed = 1;
        end
        m_run = 1;
      end
      m_prev = out_p;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise();
    logic p;
    do begin
      p = out_p;
      @(negedge clk);
    end while (!(!p && out_p));
  endtask

  // Driver: set a code, let it settle, push the expected half period.
  task automatic measure(input int code);
    #1 ratio_sel = 2'(code);
    strict_hp = 0;
    tick(40);
    strict_hp = 1 << code;
    q.push_back(1 << code);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic low_after_release(input string req);
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (out_p !== 1'b0) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    int n;
    int bad;
    rst = 1'b1; ratio_sel = 2'd3; oe = 1'b1;
    tick(3);
    chk(out_p == 1'b0, "R7 reset out_p", int'(out_p), 0);
    chk(out_n == 1'b1, "R7 reset out_n", int'(out_n), 1);
    #1 rst = 1'b0;
    low_after_release("R7 low after release");

    // R1/R2 sweeps in two orders
    for (int c = 0; c < 4; c++) measure(c);
    measure(3); measure(1); measure(2); measure(0);

    // R6: change during a high phase
    #1 ratio_sel = 2'd3; strict_hp = 0;
    tick(40);
    wait_rise();
    tick(2);
    #1 ratio_sel = 2'd0;
    n = 3;
    @(negedge clk);
    while (out_p) begin n++; @(negedge clk); end
    chk(n == 8, "R6 high in progress keeps old length", n, 8);
    n = 1; @(negedge clk);
    while (!out_p) begin n++; @(negedge clk); end
    chk(n == 1, "R6 next low uses new length", n, 1);
    n = 1; @(negedge clk);
    while (out_p) begin n++; @(negedge clk); end
    chk(n == 1, "R6 next high uses new length", n, 1);

    // R6: change during a low phase
    #1 ratio_sel = 2'd2;
    tick(40);
    wait_rise();
    while (out_p) @(negedge clk);
    #1 ratio_sel = 2'd1;
    n = 1; @(negedge clk);
    while (!out_p) begin n++; @(negedge clk); end
    chk(n == 4, "R6 low in progress keeps old length", n, 4);
    n = 1; @(negedge clk);
    while (out_p) begin n++; @(negedge clk); end
    chk(n == 4, "R6 following high keeps old length", n, 4);
    n = 1; @(negedge clk);
    while (!out_p) begin n++; @(negedge clk); end
    chk(n == 2, "R6 new length after boundary", n, 2);

    // R5/R4: stop mid-high, park, restart
    #1 ratio_sel = 2'd3;
    tick(40);
    strict_hp = 8;
    wait_rise();
    tick(3);
    #1 oe = 1'b0;
    tick(40);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_p !== 1'b0 || out_n !== 1'b1) bad++;
    end
    chk(bad == 0, "R4 parked low/high while disabled", bad, 0);
    tick(5);
    #1 oe = 1'b1;
    wait_rise();
    n = 1; @(negedge clk);
    while (out_p) begin n++; @(negedge clk); end
    chk(n == 8, "R5 first pulse after restart full", n, 8);

    // R5: short enable drop inside a high phase has no effect
    wait_rise();
    tick(2);
    #1 oe = 1'b0;
    tick(2);
    #1 oe = 1'b1;
    n = 5;
    @(negedge clk);
    while (out_p) begin n++; @(negedge clk); end
    chk(n == 8, "R5 brief enable drop ignored", n, 8);
    n = 1; @(negedge clk);
    while (!out_p) begin n++; @(negedge clk); end
    chk(n == 8, "R5 low after brief drop normal", n, 8);
    tick(40);

    // R7: reset in the middle of a pulse
    strict_hp = 0;
    wait_rise();
    tick(2);
    #1 rst = 1'b1;
    @(negedge clk);
    chk(out_p == 1'b0, "R7 reset mid-pulse out_p", int'(out_p), 0);
    chk(out_n == 1'b1, "R7 reset mid-pulse out_n", int'(out_n), 1);
    tick(1);
    #1 rst = 1'b0;
    low_after_release("R7 low after mid-pulse reset");
    measure(2);

    chk(pair_bad == 0, "R3 complement pair", pair_bad, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule